// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This block runs the refill of one cache line after a read miss. The line is 64 bytes and arrives from the next memory level as eight 8-byte beats. When a miss is accepted, the controller captures the beat that holds the missed address and issues one fetch command to memory. In the default mode the fetch starts at that beat and wraps around the line. In linear mode it starts at beat 0 and runs in ascending order, so the two fetch schemes can be compared cycle for cycle.

Each beat that returns is written into the line buffer through a one-hot write enable. When the critical beat lands, a single restart pulse hands its data straight back to the processor, so the processor does not wait for the whole line (early restart). A per-beat arrival mask and a probe port let later accesses find out whether a given beat has already landed. Those accesses can be served before the fill ends, and accesses to missing beats wait. After the last beat has been written, one extra cycle passes and then a line-complete pulse fires. The block refuses new misses until that pulse has been issued.

Top module: `line_fill_ctrl`

## Requirements
- R1: A miss is accepted when `req_valid` is high and `busy` is low. The critical beat index is `req_addr[5:3]`. In the cycle after acceptance, `mem_req_valid` is high for exactly one cycle. With `linear_mode` low, `mem_req_start` then equals the critical index.
- R2: With `linear_mode` high at acceptance, `mem_req_start` is 0. Restart still follows the critical beat, whatever its position in the arrival order.
- R3: `restart` is high for exactly one cycle per miss. That cycle is the one after the critical beat is sampled, and `restart_data` then holds that beat's data.
- R4: A beat sampled during a fill with index i drives `buf_we` = 1<<i and `buf_wdata` = its data in the next cycle. In every other cycle `buf_we` is 0.
- R5: A beat whose index has already landed in the current fill is ignored: no write and no restart. A beat that arrives while the block is idle is also ignored.
- R6: `beat_mask` bit i is set from the cycle after beat i is sampled and is cleared when a new miss is accepted. During a fill, `probe_hit` equals `beat_mask[probe_idx]`. When not busy, `probe_hit` is 0.
- R7: `line_done` is high for exactly one cycle, in the cycle that follows the write cycle of the eighth distinct beat.
- R8: `busy` is high from the cycle after acceptance through the `line_done` cycle and is low in the cycle after it. A request made while `busy` is high is dropped: no fetch is issued and the captured critical index is unchanged.
- R9: After reset, `busy`, `mem_req_valid`, `restart`, `buf_we`, `beat_mask` and `line_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read-miss request |
| req_addr | input | ADDR_W | Byte address of the miss |
| linear_mode | input | 1 | 1: fetch from beat 0 in order; 0: critical beat first, wrapped |
| busy | output | 1 | Fill in progress; new misses are refused |
| mem_req_valid | output | 1 | One-cycle fetch command to memory |
| mem_req_start | output | 3 | First beat index of the fetch |
| mem_beat_valid | input | 1 | Returning beat is valid |
| mem_beat_idx | input | 3 | Index of the returning beat |
| mem_beat_data | input | 64 | Data of the returning beat |
| restart | output | 1 | Critical data ready for the processor |
| restart_data | output | 64 | Critical beat data |
| buf_we | output | 8 | One-hot line buffer write enable |
| buf_wdata | output | 64 | Line buffer write data |
| probe_idx | input | 3 | Beat index queried by a hit-under-fill access |
| probe_hit | output | 1 | Queried beat has already landed |
| beat_mask | output | 8 | Per-beat arrival mask |
| line_done | output | 1 | Line-complete pulse |

## Verification
The fill path is exercised with wrapped orders that start in the middle of the line, at beat 0 and at beat 7. A middle start shows that the restart comes on the first beat. Starting at 0 and at 7 tests the wrap at both ends of the index. Linear mode with a mid-line critical word shows that the fetch start and the restart point can be separated, with the restart landing on the fourth beat. Further runs send a duplicate beat, a beat while idle, probes before and after arrival, and a new miss in the middle of a fill. These show whether the mask gates writes and restart, and whether the captured critical index survives a refused request.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
    localparam int LINE_BYTES = 64;
    localparam int BEAT_BYTES = 8;
    localparam int NBEATS     = LINE_BYTES / BEAT_BYTES;
    localparam int IDX_W      = $clog2(NBEATS);
    localparam int OFS_W      = $clog2(BEAT_BYTES);
    localparam int DATA_W     = BEAT_BYTES * 8;

    typedef logic [IDX_W-1:0]  beat_idx_t;
    typedef logic [NBEATS-1:0] beat_mask_t;
    typedef logic [DATA_W-1:0] beat_data_t;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_FILL,
        FS_DONE
    } fill_state_t;

    typedef struct packed {
        logic       valid;
        beat_idx_t  idx;
        beat_data_t data;
    } beat_t;

    function automatic beat_mask_t idx_onehot(input beat_idx_t i);
        beat_mask_t m;
        m = '0;
        m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/lfc_req_ctrl.sv
module lfc_req_ctrl
    import lfc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              linear_mode,
    input  logic              line_full,
    output fill_state_t       state,
    output beat_idx_t         crit_idx,
    output logic              accept,
    output logic              mem_req_valid,
    output beat_idx_t         mem_req_start
);
    beat_idx_t req_beat;

    assign req_beat = req_addr[OFS_W +: IDX_W];
    assign accept   = req_valid && (state == FS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= FS_IDLE;
            crit_idx      <= '0;
            mem_req_valid <= 1'b0;
            mem_req_start <= '0;
        end else begin
            mem_req_valid <= accept;
            if (accept) begin
                crit_idx      <= req_beat;
                mem_req_start <= linear_mode ? '0 : req_beat;
            end
            case (state)
                FS_IDLE: if (accept)    state <= FS_FILL;
                FS_FILL: if (line_full) state <= FS_DONE;
                FS_DONE:                state <= FS_IDLE;
                default:                state <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lfc_beat_track.sv
module lfc_beat_track
    import lfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       fill_active,
    input  beat_t      beat_in,
    output logic       take,
    output beat_mask_t mask,
    output beat_mask_t wr_en,
    output beat_data_t wr_data
);
    beat_mask_t hot;

    assign hot  = idx_onehot(beat_in.idx);
    assign take = beat_in.valid && fill_active && ((mask & hot) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask    <= '0;
            wr_en   <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= take ? hot : '0;
            if (take) wr_data <= beat_in.data;
            if (clear)     mask <= '0;
            else if (take) mask <= mask | hot;
        end
    end
endmodule

// File: rtl/lfc_restart.sv
module lfc_restart
    import lfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  beat_idx_t  beat_idx,
    input  beat_data_t beat_data,
    input  beat_idx_t  crit_idx,
    output logic       restart,
    output beat_data_t restart_data
);
    logic hit;

    assign hit = take && (beat_idx == crit_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            restart      <= 1'b0;
            restart_data <= '0;
        end else begin
            restart <= hit;
            if (hit) restart_data <= beat_data;
        end
    end
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl
    import lfc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              linear_mode,
    output logic              busy,
    output logic              mem_req_valid,
    output logic [2:0]        mem_req_start,
    input  logic              mem_beat_valid,
    input  logic [2:0]        mem_beat_idx,
    input  logic [63:0]       mem_beat_data,
    output logic              restart,
    output logic [63:0]       restart_data,
    output logic [7:0]        buf_we,
    output logic [63:0]       buf_wdata,
    input  logic [2:0]        probe_idx,
    output logic              probe_hit,
    output logic [7:0]        beat_mask,
    output logic              line_done
);
    fill_state_t state;
    beat_idx_t   crit_idx;
    logic        accept;
    logic        take;
    beat_mask_t  mask;
    beat_t       beat_in;

    assign beat_in = '{valid: mem_beat_valid, idx: mem_beat_idx, data: mem_beat_data};

    lfc_req_ctrl #(.ADDR_W(ADDR_W)) u_req (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .linear_mode  (linear_mode),
        .line_full    (&mask),
        .state        (state),
        .crit_idx     (crit_idx),
        .accept       (accept),
        .mem_req_valid(mem_req_valid),
        .mem_req_start(mem_req_start)
    );

    lfc_beat_track u_track (
        .clk        (clk),
        .rst        (rst),
        .clear      (accept),
        .fill_active(state == FS_FILL),
        .beat_in    (beat_in),
        .take       (take),
        .mask       (mask),
        .wr_en      (buf_we),
        .wr_data    (buf_wdata)
    );

    lfc_restart u_rst (
        .clk         (clk),
        .rst         (rst),
        .take        (take),
        .beat_idx    (beat_in.idx),
        .beat_data   (beat_in.data),
        .crit_idx    (crit_idx),
        .restart     (restart),
        .restart_data(restart_data)
    );

    assign busy      = (state != FS_IDLE);
    assign line_done = (state == FS_DONE);
    assign beat_mask = mask;
    assign probe_hit = busy && mask[probe_idx];
endmodule

// File: rtl/lfc_checker.sv
module lfc_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       busy,
    input logic       mem_req_valid,
    input logic       restart,
    input logic [7:0] buf_we,
    input logic [7:0] beat_mask,
    input logic       line_done
);
    logic [3:0] rs_cnt;

    always_ff @(posedge clk) begin
        if (rst)                rs_cnt <= '0;
        else if (mem_req_valid) rs_cnt <= '0;
        else if (restart)       rs_cnt <= rs_cnt + 4'd1;
    end

    // R1
    fetch_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> mem_req_valid);

    // R8
    fetch_only_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> $past(req_valid && !busy));

    // R3
    restart_single_chk: assert property (@(posedge clk) disable iff (rst)
        restart |-> (rs_cnt == 4'd0));

    // R3
    restart_before_done_chk: assert property (@(posedge clk) disable iff (rst)
        line_done |-> (rs_cnt == 4'd1));

    // R4
    we_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(buf_we));

    // R6
    mask_grows_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ((beat_mask & $past(beat_mask)) == $past(beat_mask)));

    // R7
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        line_done |-> ($past(buf_we) != 8'd0));

    // R8
    free_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        line_done |=> !busy);
endmodule

bind line_fill_ctrl lfc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .busy         (busy),
    .mem_req_valid(mem_req_valid),
    .restart      (restart),
    .buf_we       (buf_we),
    .beat_mask    (beat_mask),
    .line_done    (line_done)
);

// File: tb/sim_line_fill_ctrl.sv
module sim_line_fill_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        linear_mode = 1'b0;
    logic        busy, mem_req_valid;
    logic [2:0]  mem_req_start;
    logic        mem_beat_valid = 1'b0;
    logic [2:0]  mem_beat_idx = '0;
    logic [63:0] mem_beat_data = '0;
    logic        restart;
    logic [63:0] restart_data;
    logic [7:0]  buf_we;
    logic [63:0] buf_wdata;
    logic [2:0]  probe_idx = '0;
    logic        probe_hit;
    logic [7:0]  beat_mask;
    logic        line_done;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    line_fill_ctrl #(.ADDR_W(32)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .linear_mode(linear_mode), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_start(mem_req_start), .mem_beat_valid(mem_beat_valid),
        .mem_beat_idx(mem_beat_idx), .mem_beat_data(mem_beat_data),
        .restart(restart), .restart_data(restart_data), .buf_we(buf_we),
        .buf_wdata(buf_wdata), .probe_idx(probe_idx), .probe_hit(probe_hit),
        .beat_mask(beat_mask), .line_done(line_done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] addr_of(input logic [2:0] crit);
        return 32'h0000_4000 | (32'(crit) << 3) | 32'h5;
    endfunction

    // drive a request at a negedge; check the fetch command one cycle later
    task automatic issue(input logic [2:0] crit, input bit lin);
        logic [2:0] exp_start;
        exp_start   = lin ? 3'd0 : crit;
        req_valid   = 1'b1;
        req_addr    = addr_of(crit);
        linear_mode = lin;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_req_valid == 1'b1, "R1 fetch pulse", 64'(mem_req_valid), 64'd1);
        chk(mem_req_start == exp_start, lin ? "R2 linear start" : "R1 wrapped start",
            64'(mem_req_start), 64'(exp_start));
        chk(busy == 1'b1, "R8 busy after accept", 64'(busy), 64'd1);
        chk(beat_mask == 8'd0, "R6 mask cleared on accept", 64'(beat_mask), 64'd0);
        @(negedge clk);
        chk(mem_req_valid == 1'b0, "R1 fetch one cycle", 64'(mem_req_valid), 64'd0);
    endtask

    task automatic beat(input logic [2:0] idx, input logic [2:0] crit,
                        input logic [63:0] base, inout int rs);
        mem_beat_valid = 1'b1;
        mem_beat_idx   = idx;
        mem_beat_data  = base | 64'(idx);
        @(negedge clk);
        mem_beat_valid = 1'b0;
        chk(buf_we == (8'd1 << idx), "R4 write enable", 64'(buf_we), 64'(8'd1 << idx));
        chk(buf_wdata == (base | 64'(idx)), "R4 write data", buf_wdata, base | 64'(idx));
        chk(line_done == 1'b0, "R7 no early done", 64'(line_done), 64'd0);
        if (idx == crit) begin
            rs++;
            chk(restart == 1'b1, "R3 restart on critical", 64'(restart), 64'd1);
            chk(restart_data == (base | 64'(crit)), "R3 restart data", restart_data, base | 64'(crit));
        end else begin
            chk(restart == 1'b0, "R3 no restart", 64'(restart), 64'd0);
        end
    endtask

    task automatic finish_line(input int rs);
        @(negedge clk);
        chk(buf_we == 8'd0, "R4 idle write", 64'(buf_we), 64'd0);
        chk(line_done == 1'b1, "R7 done pulse", 64'(line_done), 64'd1);
        chk(busy == 1'b1, "R8 busy through done", 64'(busy), 64'd1);
        chk(beat_mask == 8'hFF, "R6 full mask", 64'(beat_mask), 64'hFF);
        chk(rs == 1, "R3 one restart per miss", 64'(rs), 64'd1);
        @(negedge clk);
        chk(line_done == 1'b0, "R7 done single cycle", 64'(line_done), 64'd0);
        chk(busy == 1'b0, "R8 free after done", 64'(busy), 64'd0);
    endtask

    task automatic run_fill(input logic [2:0] crit, input bit lin, input logic [63:0] base);
        int rs = 0;
        logic [2:0] st;
        st = lin ? 3'd0 : crit;
        issue(crit, lin);
        for (int k = 0; k < 8; k++) beat(st + 3'(k), crit, base, rs);
        finish_line(rs);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R9 busy", 64'(busy), 64'd0);
        chk(mem_req_valid == 1'b0, "R9 fetch", 64'(mem_req_valid), 64'd0);
        chk(restart == 1'b0, "R9 restart", 64'(restart), 64'd0);
        chk(buf_we == 8'd0, "R9 write", 64'(buf_we), 64'd0);
        chk(beat_mask == 8'd0, "R9 mask", 64'(beat_mask), 64'd0);
        chk(line_done == 1'b0, "R9 done", 64'(line_done), 64'd0);
    endtask

    task automatic t_wrapped();
        run_fill(3'd5, 1'b0, 64'hA500_0000_0000_0000);
        run_fill(3'd0, 1'b0, 64'hB000_0000_0000_0000);
        run_fill(3'd7, 1'b0, 64'hB700_0000_0000_0000);
    endtask

    task automatic t_linear();
        run_fill(3'd3, 1'b1, 64'hC300_0000_0000_0000);
    endtask

    task automatic t_refuse();
        int rs = 0;
        logic [63:0] base = 64'hD600_0000_0000_0000;
        issue(3'd6, 1'b1);
        beat(3'd0, 3'd6, base, rs);
        beat(3'd1, 3'd6, base, rs);
        req_valid   = 1'b1;
        req_addr    = addr_of(3'd4);
        linear_mode = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_req_valid == 1'b0, "R8 refused while busy", 64'(mem_req_valid), 64'd0);
        for (int k = 2; k < 8; k++) beat(3'(k), 3'd6, base, rs);
        finish_line(rs);
    endtask

    task automatic t_probe_dup();
        int rs = 0;
        logic [63:0] base = 64'hE400_0000_0000_0000;
        issue(3'd4, 1'b0);
        beat(3'd4, 3'd4, base, rs);
        beat(3'd5, 3'd4, base, rs);
        chk(beat_mask == 8'h30, "R6 partial mask", 64'(beat_mask), 64'h30);
        probe_idx = 3'd5;
        #1 chk(probe_hit == 1'b1, "R6 probe landed", 64'(probe_hit), 64'd1);
        probe_idx = 3'd6;
        #1 chk(probe_hit == 1'b0, "R6 probe pending", 64'(probe_hit), 64'd0);
        @(negedge clk);
        mem_beat_valid = 1'b1;
        mem_beat_idx   = 3'd4;
        mem_beat_data  = 64'hDEAD_BEEF_0000_0004;
        @(negedge clk);
        mem_beat_valid = 1'b0;
        chk(buf_we == 8'd0, "R5 duplicate no write", 64'(buf_we), 64'd0);
        chk(restart == 1'b0, "R5 duplicate no restart", 64'(restart), 64'd0);
        chk(beat_mask == 8'h30, "R5 mask unchanged", 64'(beat_mask), 64'h30);
        for (int k = 2; k < 8; k++) beat(3'd4 + 3'(k), 3'd4, base, rs);
        finish_line(rs);
        probe_idx = 3'd2;
        #1 chk(probe_hit == 1'b0, "R6 no hit when idle", 64'(probe_hit), 64'd0);
        @(negedge clk);
        mem_beat_valid = 1'b1;
        mem_beat_idx   = 3'd2;
        mem_beat_data  = 64'h1234;
        @(negedge clk);
        mem_beat_valid = 1'b0;
        chk(buf_we == 8'd0, "R5 idle beat no write", 64'(buf_we), 64'd0);
        chk(restart == 1'b0, "R5 idle beat no restart", 64'(restart), 64'd0);
        chk(busy == 1'b0, "R5 idle beat no fill", 64'(busy), 64'd0);
    endtask

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_wrapped();
        t_linear();
        t_refuse();
        t_probe_dup();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule